// File: doc/BRIEF.md
# Three-Bank Modulo-Three Interleaved Memory

This block stores words in three banks and picks the bank of each word from the remainder of its address after division by three; the quotient selects the row inside that bank. Since any three consecutive addresses have three different remainders, a run of three adjacent words always occupies all three banks and can be read in a single cycle. The block offers one write port and three read ports, joined to the banks through a crossbar that is settled again in every cycle.

Requests are arbitrated combinationally in the cycle they are presented. Writes always win. Read ports are served next, lowest number first, and a port whose bank is already taken sees its ready flag low and must present the request again. Read port 0 also has a triple mode. In that mode it takes all three banks and returns the word at its address and the two words after it on output lanes 0, 1 and 2. Read data comes back one clock after the grant, on the lane of the port that asked for it.

Top module: `tri_bank_mem`

## Requirements
- R1: A word written at address A is stored in bank (A mod 3), row (A div 3). A later granted read of A returns the last data written there.
- R2: Read requests on ports 0, 1 and 2 whose addresses fall in three different banks are all granted in the same cycle, and `rd_ready` is high for each of them.
- R3: When two or more non-triple reads target one bank, only the lowest-numbered port among them is granted. The others see `rd_ready` low in that cycle.
- R4: A write (`wr_en` high) is always carried out in the cycle it is presented. A read to the same bank as that write gets `rd_ready` low.
- R5: A read granted in cycle N gives `rd_valid` high and the data on its own lane of `rd_data` in cycle N+1. A lane with no grant in cycle N has `rd_valid` low in cycle N+1.
- R6: With `rd_en[0]` and `p0_triple` high and the request granted, lanes 0, 1 and 2 carry the words at base, base+1 and base+2 one cycle later. All three lanes are valid, and ports 1 and 2 are refused in that cycle.
- R7: A triple request is refused (`rd_ready[0]` low) when a write is present in the same cycle or when base+2 is past the top address. Ports 1 and 2 then arbitrate as usual.
- R8: Reset (`rst_n` low) clears `rd_valid` to 3'b000, including any read granted in the cycle where reset is applied.
- R9: `rd_ready[i]` is never high unless `rd_en[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the lane state |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 3 | Read request, one bit per read port |
| p0_triple | input | 1 | Puts read port 0 in three-adjacent-word mode |
| rd_addr | input | 3 x AW | Read address per port (base address for port 0 in triple mode) |
| rd_ready | output | 3 | Grant per read port, same cycle as the request |
| rd_valid | output | 3 | Lane data valid, one cycle after the grant |
| rd_data | output | 3 x DW | Read data per output lane |

## Verification
Grants are combinational, so `rd_ready` is sampled one time step after the inputs change at the falling edge, before the next rising edge. Read data passes through one register, the bank output, so `rd_valid` and `rd_data` are sampled at the falling edge after the grant edge. Each step of the vector table keeps the inputs idle for one cycle, so every result can only come from the step before. The expected lane contents come from a memory model in the bench, which is updated only after the reads of the same step have been scored.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
   localparam int NUM_BANKS = 3;
   localparam int NUM_RPORTS = 3;
   // address decoders: read ports, triple lanes, write port
   localparam int NUM_MAPS = 2 * NUM_RPORTS + 1;
   localparam int WR_MAP = 2 * NUM_RPORTS;

   typedef logic [1:0] bank_t;
   typedef logic [1:0] lane_t;

   function automatic int bank_depth(int aw);
      return ((1 << aw) + 2) / 3;
   endfunction

   function automatic int row_width(int aw);
      return $clog2(bank_depth(aw));
   endfunction
endpackage

// File: rtl/tbm_addr_map.sv
module tbm_addr_map
   import tbm_pkg::*;
#(
   parameter int AW = 8,
   parameter int RW = 7,
   parameter bit RECIP = 1'b1
) (
   input  logic [AW-1:0] addr,
   output bank_t         bank,
   output logic [RW-1:0] row
);
   // even shift so that 2**SH mod 3 == 1 and the multiplier error stays below one
   localparam int SH = AW + 2 + (AW % 2);
   localparam int PW = AW + SH;
   localparam longint MAGIC = ((longint'(1) << SH) + 2) / 3;

   logic [AW-1:0] quo;
   logic [1:0]    three_q_lo;

   generate
      if (RECIP) begin : g_recip
         logic [PW-1:0] prod;
         logic          unused_lo;
         assign prod = {{SH{1'b0}}, addr} * PW'(MAGIC);
         assign quo  = prod[SH +: AW];
         assign unused_lo = ^prod[SH-1:0];
      end else begin : g_div
         assign quo = addr / AW'(3);
      end
   endgenerate

   // remainder = addr - 3*quo, only the two low bits are needed
   assign three_q_lo = quo[1:0] + {quo[0], 1'b0};
   assign bank       = bank_t'(addr[1:0] - three_q_lo);
   assign row        = quo[RW-1:0];

   logic unused_hi;
   assign unused_hi = ^quo[AW-1:RW];
endmodule

// File: rtl/tbm_xbar_arb.sv
module tbm_xbar_arb
   import tbm_pkg::*;
#(
   parameter int RW = 7
) (
   input  logic                            wr_en,
   input  bank_t                           wr_bank,
   input  logic [NUM_RPORTS-1:0]           rd_en,
   input  logic                            p0_triple,
   input  logic                            trip_in_range,
   input  bank_t [NUM_RPORTS-1:0]          port_bank,
   input  logic  [NUM_RPORTS-1:0][RW-1:0]  port_row,
   input  bank_t [NUM_RPORTS-1:0]          trip_bank,
   input  logic  [NUM_RPORTS-1:0][RW-1:0]  trip_row,
   output logic [NUM_RPORTS-1:0]           grant,
   output logic [NUM_BANKS-1:0]            bank_we,
   output logic [NUM_BANKS-1:0]            bank_re,
   output logic [NUM_BANKS-1:0][RW-1:0]    bank_rrow,
   output lane_t [NUM_BANKS-1:0]           bank_lane
);
   logic [NUM_BANKS-1:0] busy;
   logic                 trip_req;

   assign trip_req = rd_en[0] & p0_triple;

   always_comb begin
      busy      = '0;
      bank_we   = '0;
      bank_re   = '0;
      grant     = '0;
      bank_rrow = '0;
      bank_lane = '0;

      // the write port owns its bank before any read is looked at
      if (wr_en) begin
         busy[wr_bank]    = 1'b1;
         bank_we[wr_bank] = 1'b1;
      end

      // triple fetch needs every bank, so any write blocks it
      if (trip_req && trip_in_range && !wr_en) begin
         grant[0] = 1'b1;
         busy     = '1;
         for (int k = 0; k < NUM_RPORTS; k++) begin
            bank_re[trip_bank[k]]   = 1'b1;
            bank_rrow[trip_bank[k]] = trip_row[k];
            bank_lane[trip_bank[k]] = lane_t'(k);
         end
      end

      // single reads in fixed order, lowest port first
      for (int i = 0; i < NUM_RPORTS; i++) begin
         if (rd_en[i] && !(i == 0 && p0_triple) && !busy[port_bank[i]]) begin
            grant[i]                = 1'b1;
            busy[port_bank[i]]      = 1'b1;
            bank_re[port_bank[i]]   = 1'b1;
            bank_rrow[port_bank[i]] = port_row[i];
            bank_lane[port_bank[i]] = lane_t'(i);
         end
      end
   end
endmodule

// File: rtl/tbm_bank.sv
module tbm_bank #(
   parameter int DW = 16,
   parameter int RW = 7,
   parameter int DEPTH = 86
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] wrow,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [RW-1:0] rrow,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wrow] <= wdata;
      if (re) rdata <= mem[rrow];
   end
endmodule

// File: rtl/tri_bank_mem.sv
module tri_bank_mem
   import tbm_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16,
   parameter bit RECIP_DIV = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [DW-1:0]          wr_data,
   input  logic [2:0]             rd_en,
   input  logic                   p0_triple,
   input  logic [2:0][AW-1:0]     rd_addr,
   output logic [2:0]             rd_ready,
   output logic [2:0]             rd_valid,
   output logic [2:0][DW-1:0]     rd_data
);
   localparam int DEPTH = bank_depth(AW);
   localparam int RW = row_width(AW);
   localparam logic [AW-1:0] TRIP_MAX = AW'((1 << AW) - 3);

   generate
      if (AW < 3 || AW > 16) begin : g_bad_aw
         $error("tri_bank_mem: AW must lie in 3..16");
      end
      if (DW < 1) begin : g_bad_dw
         $error("tri_bank_mem: DW must be positive");
      end
   endgenerate

   // address decode: one mapper per read port, per triple lane, and the write port
   logic  [NUM_MAPS-1:0][AW-1:0] map_addr;
   bank_t [NUM_MAPS-1:0]         map_bank;
   logic  [NUM_MAPS-1:0][RW-1:0] map_row;

   genvar m;
   generate
      for (m = 0; m < NUM_MAPS; m++) begin : g_map
         if (m < NUM_RPORTS) begin : g_port
            assign map_addr[m] = rd_addr[m];
         end else if (m < WR_MAP) begin : g_trip
            assign map_addr[m] = rd_addr[0] + AW'(m - NUM_RPORTS);
         end else begin : g_wr
            assign map_addr[m] = wr_addr;
         end
         tbm_addr_map #(.AW(AW), .RW(RW), .RECIP(RECIP_DIV)) u_map (
            .addr (map_addr[m]),
            .bank (map_bank[m]),
            .row  (map_row[m])
         );
      end
   endgenerate

   logic trip_in_range;
   assign trip_in_range = (rd_addr[0] <= TRIP_MAX);

   logic [NUM_RPORTS-1:0]        grant;
   logic [NUM_BANKS-1:0]         bank_we;
   logic [NUM_BANKS-1:0]         bank_re;
   logic [NUM_BANKS-1:0][RW-1:0] bank_rrow;
   lane_t [NUM_BANKS-1:0]        bank_lane;

   tbm_xbar_arb #(.RW(RW)) u_arb (
      .wr_en         (wr_en),
      .wr_bank       (map_bank[WR_MAP]),
      .rd_en         (rd_en),
      .p0_triple     (p0_triple),
      .trip_in_range (trip_in_range),
      .port_bank     (map_bank[NUM_RPORTS-1:0]),
      .port_row      (map_row[NUM_RPORTS-1:0]),
      .trip_bank     (map_bank[WR_MAP-1:NUM_RPORTS]),
      .trip_row      (map_row[WR_MAP-1:NUM_RPORTS]),
      .grant         (grant),
      .bank_we       (bank_we),
      .bank_re       (bank_re),
      .bank_rrow     (bank_rrow),
      .bank_lane     (bank_lane)
   );

   logic [NUM_BANKS-1:0][DW-1:0] bank_q;

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         tbm_bank #(.DW(DW), .RW(RW), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .wrow  (map_row[WR_MAP]),
            .wdata (wr_data),
            .re    (bank_re[b]),
            .rrow  (bank_rrow[b]),
            .rdata (bank_q[b])
         );
      end
   endgenerate

   // return path: remember which bank feeds each lane for one cycle
   logic  [NUM_RPORTS-1:0] lane_vld_d, lane_vld_q;
   bank_t [NUM_RPORTS-1:0] lane_src_d, lane_src_q;

   always_comb begin
      lane_vld_d = '0;
      lane_src_d = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (bank_re[k]) begin
            lane_vld_d[bank_lane[k]] = 1'b1;
            lane_src_d[bank_lane[k]] = bank_t'(k);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_vld_q <= '0;
         lane_src_q <= '0;
      end else begin
         lane_vld_q <= lane_vld_d;
         lane_src_q <= lane_src_d;
      end
   end

   always_comb begin
      for (int k = 0; k < NUM_RPORTS; k++) begin
         rd_data[k] = bank_q[lane_src_q[k]];
      end
   end

   assign rd_ready = grant;
   assign rd_valid = lane_vld_q;
endmodule

// File: rtl/tbm_chk.sv
module tbm_chk #(
   parameter int AW = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [AW-1:0]      wr_addr,
   input logic [2:0]         rd_en,
   input logic               p0_triple,
   input logic [2:0][AW-1:0] rd_addr,
   input logic [2:0]         rd_ready,
   input logic [2:0]         rd_valid
);
   // R9
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready & ~rd_en) == 3'b000);

   // R5
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready == 3'b000 |=> rd_valid == 3'b000);

   // R6
   trip_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[0] && p0_triple && rd_ready[0]) |=> rd_valid == 3'b111);

   // R6
   trip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[0] && p0_triple && rd_ready[0]) |-> rd_ready[2:1] == 2'b00);

   // R7
   trip_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[0] && p0_triple && wr_en) |-> !rd_ready[0]);

   // R3
   p0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[0] && !p0_triple && !(wr_en && (int'(wr_addr) % 3 == int'(rd_addr[0]) % 3)))
      |-> rd_ready[0]);

   genvar i, j;
   generate
      for (i = 0; i < 3; i++) begin : g_port
         // R5
         grant_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ready[i] |=> rd_valid[i]);

         // R4
         wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && rd_en[i] && !(i == 0 && p0_triple)
             && (int'(rd_addr[i]) % 3 == int'(wr_addr) % 3)) |-> !rd_ready[i]);

         for (j = i + 1; j < 3; j++) begin : g_pair
            // R3
            distinct_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (rd_ready[i] && rd_ready[j] && !(i == 0 && p0_triple))
               |-> (int'(rd_addr[i]) % 3 != int'(rd_addr[j]) % 3));
         end
      end
   endgenerate
endmodule

bind tri_bank_mem tbm_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .rd_en     (rd_en),
   .p0_triple (p0_triple),
   .rd_addr   (rd_addr),
   .rd_ready  (rd_ready),
   .rd_valid  (rd_valid)
);

// File: tb/tb_tri_bank_mem.sv
module tb_tri_bank_mem;
   localparam int AW = 8;
   localparam int DW = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               wr_en = 1'b0;
   logic [AW-1:0]      wr_addr = '0;
   logic [DW-1:0]      wr_data = '0;
   logic [2:0]         rd_en = '0;
   logic               p0_triple = 1'b0;
   logic [2:0][AW-1:0] rd_addr = '0;
   logic [2:0]         rd_ready;
   logic [2:0]         rd_valid;
   logic [2:0][DW-1:0] rd_data;

   always #5 clk = ~clk;

   tri_bank_mem #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .p0_triple(p0_triple), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int checks = 0;
   int fails = 0;
   logic [DW-1:0] model [1 << AW];

   typedef struct packed {
      logic [3:0]    req;
      logic          wen;
      logic [AW-1:0] wa;
      logic [DW-1:0] wd;
      logic [2:0]    ren;
      logic          trip;
      logic [AW-1:0] a0;
      logic [AW-1:0] a1;
      logic [AW-1:0] a2;
      logic [2:0]    rdy;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{4'd2, 1'b0, 8'd0, 16'h0000, 3'b111, 1'b0, 8'd3,   8'd4, 8'd5, 3'b111}, // R2 banks 0,1,2
      '{4'd3, 1'b0, 8'd0, 16'h0000, 3'b111, 1'b0, 8'd1,   8'd4, 8'd2, 3'b101}, // R3 ports 0,1 share bank 1
      '{4'd3, 1'b0, 8'd0, 16'h0000, 3'b110, 1'b0, 8'd0,   8'd6, 8'd0, 3'b010}, // R3 ports 1,2 share bank 0
      '{4'd4, 1'b1, 8'd7, 16'h5C5C, 3'b111, 1'b0, 8'd4,   8'd5, 8'd6, 3'b110}, // R4 write bank 1 blocks port 0
      '{4'd6, 1'b0, 8'd0, 16'h0000, 3'b111, 1'b1, 8'd2,   8'd0, 8'd1, 3'b001}, // R6 base 2
      '{4'd7, 1'b1, 8'd8, 16'hBEEF, 3'b001, 1'b1, 8'd6,   8'd0, 8'd0, 3'b000}, // R7 write blocks triple
      '{4'd1, 1'b0, 8'd0, 16'h0000, 3'b100, 1'b0, 8'd0,   8'd0, 8'd7, 3'b100}, // R1 read back of write
      '{4'd7, 1'b0, 8'd0, 16'h0000, 3'b011, 1'b1, 8'd254, 8'd3, 8'd0, 3'b010}, // R7 past top, port 1 served
      '{4'd6, 1'b0, 8'd0, 16'h0000, 3'b001, 1'b1, 8'd253, 8'd0, 8'd0, 3'b001}, // R6 last legal base
      '{4'd4, 1'b1, 8'd2, 16'h7777, 3'b001, 1'b0, 8'd8,   8'd0, 8'd0, 3'b000}, // R4 write bank 2 blocks read of 8
      '{4'd1, 1'b0, 8'd0, 16'h0000, 3'b011, 1'b0, 8'd8,   8'd2, 8'd0, 3'b001}, // R1 data written while triple refused
      '{4'd1, 1'b0, 8'd0, 16'h0000, 3'b010, 1'b0, 8'd0,   8'd2, 8'd0, 3'b010}  // R1 new data at 2
   };

   function automatic logic [DW-1:0] pat(int a);
      return DW'(16'h1000 + a * 7);
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic write_word(int a);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(a);
      model[a] = pat(a);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle();
      wr_en = 1'b0; rd_en = '0; p0_triple = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
   end

   initial begin
      logic [2:0]         ev;
      logic [2:0][DW-1:0] ed;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 valid in reset", DW'(rd_valid), '0);
      check("R9 ready with no request", DW'(rd_ready), '0);
      rst_n = 1'b1;

      for (int a = 0; a < 9; a++) write_word(a);
      for (int a = 250; a < 256; a++) write_word(a);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         wr_en = VT[v].wen; wr_addr = VT[v].wa; wr_data = VT[v].wd;
         rd_en = VT[v].ren; p0_triple = VT[v].trip;
         rd_addr[0] = VT[v].a0; rd_addr[1] = VT[v].a1; rd_addr[2] = VT[v].a2;
         #1;
         for (int i = 0; i < 3; i++)
            check($sformatf("R%0d vec%0d ready port%0d", VT[v].req, v, i),
                  DW'(rd_ready[i]), DW'(VT[v].rdy[i]));
         ev = '0; ed = '0;
         if (VT[v].trip && VT[v].rdy[0]) begin
            ev = 3'b111;
            for (int k = 0; k < 3; k++) ed[k] = model[int'(VT[v].a0) + k];
         end else begin
            ev = VT[v].rdy;
            ed[0] = model[VT[v].a0]; ed[1] = model[VT[v].a1]; ed[2] = model[VT[v].a2];
         end
         if (VT[v].wen) model[VT[v].wa] = VT[v].wd;
         @(negedge clk);
         idle();
         // R5 data one cycle after the grant, on the port's own lane
         for (int k = 0; k < 3; k++) begin
            check($sformatf("R5 vec%0d valid lane%0d", v, k), DW'(rd_valid[k]), DW'(ev[k]));
            if (ev[k])
               check($sformatf("R%0d vec%0d data lane%0d", VT[v].req, v, k), rd_data[k], ed[k]);
         end
      end

      // R8 reset applied in the grant cycle clears the pending lane
      @(negedge clk);
      rd_en = 3'b001; rd_addr[0] = 8'd3;
      #1;
      check("R8 grant before reset", DW'(rd_ready[0]), 16'd1);
      rst_n = 1'b0;
      @(negedge clk);
      idle();
      check("R8 valid after reset edge", DW'(rd_valid), '0);
      rst_n = 1'b1;

      // R9 triple flag alone requests nothing
      @(negedge clk);
      p0_triple = 1'b1; rd_addr[0] = 8'd0;
      #1;
      check("R9 triple flag without enable", DW'(rd_ready), '0);
      @(negedge clk);
      idle();
      check("R5 no valid without grant", DW'(rd_valid), '0);

      report();
   end
endmodule